// File: doc/BRIEF.md
# Rotating Digit-Serial Number Store

This block holds the working numbers of a small calculator as digit streams that never stop moving. It has three number registers: the entry being typed, the running subtotal and the result. Each register is four 1-bit recirculating loops side by side, one per BCD weight, so a whole 4-bit digit occupies one position across the four loops. Every loop is eleven positions long. Eight positions carry digits, one carries the sign, one carries the overflow flag, and one is a gap that always stays empty. Every clock moves every digit by one position.

The control logic sees only the loop head. A shared position counter reports which slot is there now. While a slot passes the head, the control logic can read its digit and may put a replacement digit back into the loop in its place. A pulse marks slot 0, the least significant digit, so that serial arithmetic can start there. A separate 9-bit register holds a plain binary constant for multiply and divide. It is loaded in parallel. A synchronous clear empties every store at once.

Top module: `calc_digit_store`

## Requirements
- R1: The digit at the head of register r is shown on `rd_digit[4r+3:4r]`, where r is 0 for entry, 1 for subtotal and 2 for result. Reading does not destroy it. A digit put into slot k is shown again when `slot_idx` next equals k, 11 cycles later, and again in every frame after that until it is replaced.
- R2: `slot_idx` is 0 after reset. It rises by one each clock, and after 10 it returns to 0.
- R3: `frame_start` is high in exactly those cycles in which `slot_idx` is 0.
- R4: When `wr_en[r]` is high in a cycle, `wr_digit[4r+3:4r]` replaces the head digit of register r. When it is low, the head digit goes back into the loop unchanged.
- R5: Slot 8 holds the sign and slot 9 holds the overflow flag. In these two slots only bit 0 is stored. Bits 3 to 1 of any digit written there read back as 0.
- R6: Slot 10 is the gap. It always reads 0, and writes to it have no effect.
- R7: A write to one register never changes the contents of the other two registers.
- R8: When `clr` is high, every slot of all three registers and `const_q` read 0 from the next cycle on. `clr` wins over writes and over a constant load in the same cycle. `clr` does not disturb `slot_idx`.
- R9: When `const_ld` is high, `const_q` takes the value of `const_din` on the next cycle. Otherwise `const_q` holds its value.
- R10: While `rst_n` is low, `slot_idx` is 0, `frame_start` is 1, and all digits and `const_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all stores |
| slot_idx | output | 4 | Number of the slot now at the loop head |
| frame_start | output | 1 | High when slot 0 is at the head |
| wr_en | input | 3 | Per-register replace enable at the head |
| wr_digit | input | 12 | Replacement digits, 4 bits per register |
| rd_digit | output | 12 | Head digits, 4 bits per register |
| const_ld | input | 1 | Parallel load enable for the constant |
| const_din | input | 9 | Binary constant to load |
| const_q | output | 9 | Stored binary constant |

## Verification
The hard case is a write whose effect shows only one full frame later and only at one slot. A wrong slot mask, or a value that lands one position off, looks correct until that slot comes back to the head. The stimulus therefore fills whole frames, including the sign, overflow and gap slots, with values that have their upper bits set. It then runs idle frames, and a scoreboard holds an expected value for every head cycle. A clear is issued in the same cycle as writes and a constant load. This shows that the clear wins, and that the counter keeps running through it.

// File: rtl/calc_store_pkg.sv
package calc_store_pkg;
    localparam int SLOTS     = 11;
    localparam int SLOT_W    = 4;
    localparam int BCD_W     = 4;
    localparam int SIGN_SLOT = 8;
    localparam int OVF_SLOT  = 9;
    localparam int GAP_SLOT  = 10;
    localparam int NUM_REGS  = 3;
    localparam int CONST_W   = 9;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } ctr_state_t;
endpackage

// File: rtl/loop_slot_ctr.sv
module loop_slot_ctr
    import calc_store_pkg::*;
#(
    parameter int NSLOT = SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              at_first
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLOT - 1);

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.slot == LAST) st_d.slot = '0;
        else                   st_d.slot = st_q.slot + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot     = st_q.slot;
    assign at_first = (st_q.slot == '0);

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == LAST) |=> (slot == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != LAST) |=> (slot == $past(slot) + 1'b1)); // R2
endmodule

// File: rtl/digit_loop.sv
module digit_loop
    import calc_store_pkg::*;
#(
    parameter int NSLOT = SLOTS,
    parameter int DW    = BCD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [SLOT_W-1:0] slot,
    input  logic              we,
    input  logic [DW-1:0]     wdig,
    output logic [DW-1:0]     head
);
    localparam logic [SLOT_W-1:0] S_SIGN = SLOT_W'(SIGN_SLOT);
    localparam logic [SLOT_W-1:0] S_OVF  = SLOT_W'(OVF_SLOT);
    localparam logic [SLOT_W-1:0] S_GAP  = SLOT_W'(GAP_SLOT);

    logic [NSLOT-1:0] ring_d [DW];
    logic [NSLOT-1:0] ring_q [DW];
    logic [DW-1:0]    entry_d;
    logic [DW-1:0]    tail_w;
    logic             is_flag, is_gap;

    assign is_flag = (slot == S_SIGN) || (slot == S_OVF);
    assign is_gap  = (slot == S_GAP);

    always_comb begin
        entry_d = head;
        if (we)      entry_d = wdig;
        if (is_flag) entry_d[DW-1:1] = '0;
        if (is_gap)  entry_d = '0;
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign head[b]   = ring_q[b][0];
        assign tail_w[b] = ring_q[b][NSLOT-1];

        always_comb begin
            if (clr) ring_d[b] = '0;
            else     ring_d[b] = {entry_d[b], ring_q[b][NSLOT-1:1]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q[b] <= '0;
            else        ring_q[b] <= ring_d[b];
        end
    end

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        is_gap |-> (head == '0)); // R6
    AST_FLAG_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        is_flag |-> (head[DW-1:1] == '0)); // R5
    AST_RECIRC: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !we && !is_gap) |=> (tail_w == $past(head))); // R4
    AST_CLEAR_RING: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (head == '0)); // R8
endmodule

// File: rtl/const_store.sv
module const_store
    import calc_store_pkg::*;
#(
    parameter int CW = CONST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] q
);
    logic [CW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)     val_d = '0;
        else if (ld) val_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign q = val_q;

    AST_CONST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld) |=> $stable(q)); // R9
    AST_CONST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld) |=> (q == $past(din))); // R9
    AST_CONST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R8
endmodule

// File: rtl/calc_digit_store.sv
module calc_digit_store
    import calc_store_pkg::*;
#(
    parameter int NREG  = NUM_REGS,
    parameter int DW    = BCD_W,
    parameter int CW    = CONST_W,
    parameter int NSLOT = SLOTS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic               frame_start,
    input  logic [NREG-1:0]    wr_en,
    input  logic [NREG*DW-1:0] wr_digit,
    output logic [NREG*DW-1:0] rd_digit,
    input  logic               const_ld,
    input  logic [CW-1:0]      const_din,
    output logic [CW-1:0]      const_q
);
    logic [SLOT_W-1:0] slot_w;

    loop_slot_ctr #(.NSLOT(NSLOT)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot_w),
        .at_first (frame_start)
    );

    assign slot_idx = slot_w;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        digit_loop #(.NSLOT(NSLOT), .DW(DW)) u_loop (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .slot  (slot_w),
            .we    (wr_en[r]),
            .wdig  (wr_digit[r*DW +: DW]),
            .head  (rd_digit[r*DW +: DW])
        );
    end

    const_store #(.CW(CW)) u_const (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ld    (const_ld),
        .din   (const_din),
        .q     (const_q)
    );

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (slot_idx == SLOT_W'(1))); // R3
endmodule

// File: tb/calc_digit_store_test.sv
`timescale 1ns/1ps
module calc_digit_store_test;
    localparam int NR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  slot_idx;
    logic        frame_start;
    logic [2:0]  wr_en = '0;
    logic [11:0] wr_digit = '0;
    logic [11:0] rd_digit;
    logic        const_ld = 1'b0;
    logic [8:0]  const_din = '0;
    logic [8:0]  const_q;

    always #2 clk = ~clk;

    calc_digit_store uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .slot_idx(slot_idx),
        .frame_start(frame_start), .wr_en(wr_en), .wr_digit(wr_digit),
        .rd_digit(rd_digit), .const_ld(const_ld), .const_din(const_din),
        .const_q(const_q)
    );

    typedef struct {
        int          slot;
        logic [11:0] rd;
        logic [8:0]  cq;
        string       dtag;
        string       ctag;
    } item_t;

    item_t      sb[$];
    logic [3:0] model [NR][11];
    logic [8:0] cmodel;
    int         slot_m;
    int         clr_recent;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: queue expectations for the current head, then drive and update model
    task automatic step(input logic [2:0] we, input logic [11:0] wd,
                        input logic c, input logic ld, input logic [8:0] din);
        item_t it;
        it.slot = slot_m;
        for (int r = 0; r < NR; r++) it.rd[r*4 +: 4] = model[r][slot_m];
        it.cq = cmodel;
        if (clr_recent > 0) begin
            it.dtag = "R8";
            it.ctag = "R8";
        end else begin
            it.dtag = (slot_m == 10) ? "R6" : (slot_m >= 8) ? "R5" : "R1/R4/R7";
            it.ctag = "R9";
        end
        sb.push_back(it);
        wr_en = we; wr_digit = wd; clr = c; const_ld = ld; const_din = din;
        if (clr_recent > 0) clr_recent--;
        if (c) begin
            for (int r = 0; r < NR; r++)
                for (int s = 0; s < 11; s++) model[r][s] = 4'h0;
            cmodel = '0;
            clr_recent = 11;
        end else begin
            for (int r = 0; r < NR; r++) begin
                if (we[r] && slot_m != 10) begin
                    model[r][slot_m] = (slot_m >= 8) ? {3'b000, wd[r*4]} : wd[r*4 +: 4];
                end
            end
            if (ld) cmodel = din;
        end
        slot_m = (slot_m == 10) ? 0 : slot_m + 1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'b000, 12'h000, 1'b0, 1'b0, 9'h000);
    endtask

    // One full frame of writes into register r; flag and gap slots get extra bits
    task automatic fill_frame(input int r, input int base, input logic [3:0] flagval);
        for (int i = 0; i < 11; i++) begin
            logic [3:0]  d;
            logic [11:0] wd;
            d = (slot_m < 8) ? 4'((base + slot_m) % 10) : flagval;
            wd = '0;
            wd[r*4 +: 4] = d;
            step(3'(1 << r), wd, 1'b0, 1'b0, 9'h000);
        end
    endtask

    // Monitor: pops one expectation per head cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(slot_idx == 4'(it.slot), "R2", "slot_idx", slot_idx, it.slot);
                check(frame_start == (it.slot == 0), "R3", "frame_start",
                      frame_start, int'(it.slot == 0));
                for (int r = 0; r < NR; r++)
                    check(rd_digit[r*4 +: 4] == it.rd[r*4 +: 4], it.dtag,
                          $sformatf("reg%0d slot%0d", r, it.slot),
                          rd_digit[r*4 +: 4], it.rd[r*4 +: 4]);
                check(const_q == it.cq, it.ctag, "const_q", const_q, it.cq);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < 11; s++) model[r][s] = 4'h0;
        cmodel = '0;
        slot_m = 0;
        clr_recent = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(slot_idx == 4'd0 && frame_start == 1'b1, "R10", "slot at reset",
              {slot_idx, frame_start}, 1);
        check(rd_digit == 12'h000 && const_q == 9'h000, "R10", "stores at reset",
              {rd_digit, const_q}, 0);
        rst_n = 1'b1;
        idle(11);
        fill_frame(0, 3, 4'hF);          // sign/ovf get 1, gap write ignored
        fill_frame(1, 7, 4'hE);          // sign/ovf get 0
        idle(22);
        // partial overwrites on result, plus a constant load
        step(3'b100, 12'h500, 1'b0, 1'b1, 9'h1A5);
        step(3'b100, 12'h900, 1'b0, 1'b0, 9'h000);
        idle(3);
        step(3'b111, 12'h321, 1'b0, 1'b1, 9'h0F3);
        idle(30);
        fill_frame(2, 0, 4'h3);
        idle(5);
        // clear together with writes and a load: clear wins
        step(3'b111, 12'h999, 1'b1, 1'b1, 9'h1FF);
        idle(14);
        fill_frame(0, 5, 4'h1);
        step(3'b010, 12'h080, 1'b0, 1'b1, 9'h101);
        idle(24);
        @(negedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule